// File: doc/BRIEF.md
# Exact-Depth Synchronous FIFO

This block is a single-clock first-in first-out queue whose capacity equals the `DEPTH` parameter exactly, including depths that are not powers of two, such as 6. Every slot is usable. No entry is held back to separate an empty queue from a full one, and no separate count or flag register is kept.

Each of the two pointers holds a slot index plus one wrap bit above it. For a depth that is not a power of two, the index jumps from the last slot straight back to zero and the wrap bit flips at the same time. The unused index codes are therefore never visited. For a depth of 6, a pointer counts 0,1,2,3,4,5,8,9,10,11,12,13 and then returns to 0. For a power-of-two depth, the pointer is a plain counter that rolls over by itself.

Empty, full and the fill level all come from comparing the two pointers. Read data falls through from the head slot whenever the queue holds data. A producer drives `pushValid` and `pushData` and watches `isFull`. A consumer sees `popData` while `isEmpty` is low and pulses `popReady` to take the entry.

Top module: `exact_fifo`

## Requirements
- R1: After a synchronous active-high `rst`, `isEmpty` is 1, `isFull` is 0 and `fillLevel` is 0.
- R2: Entries leave in the order they were accepted. While `isEmpty` is 0, `popData` shows the oldest entry combinationally, in the same cycle, before any pop.
- R3: Exactly `DEPTH` writes into an empty queue make `isFull` 1 and `fillLevel` equal to `DEPTH`. With one fewer write, `isFull` stays 0.
- R4: A push while `isFull` is 1, with no pop in that cycle, is dropped. `fillLevel` is unchanged, and the stored contents read back unaltered.
- R5: A pop while `isEmpty` is 1 is ignored. `fillLevel` stays 0, and a later push and pop work normally.
- R6: When neither full nor empty, a push and a pop in the same cycle are both taken, and `fillLevel` is unchanged.
- R7: When full, a cycle with both push and pop performs only the pop, so the level becomes `DEPTH`-1. When empty, such a cycle performs only the push, so the level becomes 1.
- R8: `fillLevel` always equals accepted pushes minus accepted pops and stays within 0..`DEPTH`, across any number of pointer wraps.
- R9: Data order and contents are preserved over many laps of both pointers, which passes repeatedly through the skipped index codes and the wrap-bit toggles.
- R10: `isFull`, `isEmpty` and `fillLevel` change in the cycle that follows the clock edge that accepts an operation, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pushValid | input | 1 | Write request |
| pushData | input | WIDTH | Write data |
| isFull | output | 1 | All DEPTH slots occupied |
| popReady | input | 1 | Read request; pops the head entry when not empty |
| popData | output | WIDTH | Head entry (fall-through) |
| isEmpty | output | 1 | No entries stored |
| fillLevel | output | clog2(DEPTH)+1 | Number of stored entries, 0..DEPTH |

## Verification
The pointers are the only state that changes with an operation, and the status outputs and head data are decoded from them combinationally. Each status or level result is therefore due exactly one clock edge after the stimulus that caused it. The head data for the current pointers is due in the same cycle the inputs are applied.

The bench drives inputs just after a falling edge. It compares `popData` one nanosecond later, before the accepting rising edge. It then compares `fillLevel`, `isFull` and `isEmpty` at the next falling edge, so each result is sampled in the cycle it becomes due. A dedicated scenario also samples before the accepting edge, to confirm that the status does not move early.

// File: rtl/exact_fifo_pkg.sv
package exact_fifo_pkg;
  typedef struct packed {
    logic doWrite;
    logic doRead;
  } fifoStrobes_t;
endpackage

// File: rtl/exact_fifo_ctrl.sv
module exact_fifo_ctrl
  import exact_fifo_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pushValid,
  input  logic                          popReady,
  output fifoStrobes_t                  strb,
  output logic [$clog2(DEPTH)-1:0]      wrIdx,
  output logic [$clog2(DEPTH)-1:0]      rdIdx,
  output logic                          full,
  output logic                          empty,
  output logic [$clog2(DEPTH):0]        level
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] DEPTH_P  = PTR_W'(DEPTH);
  localparam bit IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [PTR_W-1:0] wrPtr, rdPtr, wrNext, rdNext;
  logic wrWrap, rdWrap;

  assign wrIdx  = wrPtr[IDX_W-1:0];
  assign rdIdx  = rdPtr[IDX_W-1:0];
  assign wrWrap = wrPtr[IDX_W];
  assign rdWrap = rdPtr[IDX_W];

  assign empty = (wrPtr == rdPtr);
  assign full  = (wrIdx == rdIdx) && (wrWrap != rdWrap);

  assign strb.doWrite = pushValid && !full;
  assign strb.doRead  = popReady && !empty;

  // Pointer advance: natural rollover for powers of two, skip jump otherwise
  generate
    if (IS_POW2) begin : g_roll
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_skip
      always_comb begin
        if (wrIdx == LAST_IDX) wrNext = {~wrWrap, {IDX_W{1'b0}}};
        else                   wrNext = wrPtr + 1'b1;
        if (rdIdx == LAST_IDX) rdNext = {~rdWrap, {IDX_W{1'b0}}};
        else                   rdNext = rdPtr + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.doWrite) wrPtr <= wrNext;
      if (strb.doRead)  rdPtr <= rdNext;
    end
  end

  // Occupancy from the pointer pair
  always_comb begin
    if (wrWrap == rdWrap) level = {1'b0, wrIdx} - {1'b0, rdIdx};
    else                  level = DEPTH_P - ({1'b0, rdIdx} - {1'b0, wrIdx});
  end

  a_r3_status_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  a_r3_wr_idx_range: assert property (@(posedge clk) disable iff (rst)
    (wrIdx <= LAST_IDX) && (rdIdx <= LAST_IDX));
  a_r8_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= DEPTH_P);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (full && !popReady) |=> (full && $stable(wrPtr)));
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (empty && !pushValid) |=> (empty && $stable(rdPtr)));
  a_r8_level_up: assert property (@(posedge clk) disable iff (rst)
    (strb.doWrite && !strb.doRead) |=> (level == $past(level) + 1'b1));
  a_r8_level_down: assert property (@(posedge clk) disable iff (rst)
    (strb.doRead && !strb.doWrite) |=> (level == $past(level) - 1'b1));
  a_r6_level_hold: assert property (@(posedge clk) disable iff (rst)
    (strb.doRead == strb.doWrite) |=> $stable(level));
endmodule

// File: rtl/exact_fifo_store.sv
module exact_fifo_store
  import exact_fifo_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int WIDTH = 8
) (
  input  logic                      clk,
  input  fifoStrobes_t              strb,
  input  logic [$clog2(DEPTH)-1:0]  wrIdx,
  input  logic [$clog2(DEPTH)-1:0]  rdIdx,
  input  logic [WIDTH-1:0]          wrData,
  output logic [WIDTH-1:0]          rdData
);
  logic [WIDTH-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.doWrite) slots[wrIdx] <= wrData;
  end

  assign rdData = slots[rdIdx];
endmodule

// File: rtl/exact_fifo.sv
module exact_fifo
  import exact_fifo_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int WIDTH = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pushValid,
  input  logic [WIDTH-1:0]          pushData,
  output logic                      isFull,
  input  logic                      popReady,
  output logic [WIDTH-1:0]          popData,
  output logic                      isEmpty,
  output logic [$clog2(DEPTH):0]    fillLevel
);
  localparam int IDX_W = $clog2(DEPTH);

  fifoStrobes_t     strb;
  logic [IDX_W-1:0] wrIdx, rdIdx;

  initial begin
    if (DEPTH < 2) $error("DEPTH must be at least 2");
  end

  exact_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .pushValid(pushValid), .popReady(popReady),
    .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .full(isFull), .empty(isEmpty), .level(fillLevel)
  );

  exact_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrData(pushData), .rdData(popData)
  );
endmodule

// File: tb/exact_fifo_test.sv
`timescale 1ns/1ps
module exact_fifo_test;
  localparam int DEPTH = 6;
  localparam int WIDTH = 8;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 0;
  logic rst = 1;
  logic pushValid = 0;
  logic [WIDTH-1:0] pushData = '0;
  logic popReady = 0;
  logic isFull, isEmpty;
  logic [WIDTH-1:0] popData;
  logic [LW-1:0] fillLevel;

  int nChecks = 0;
  int nFails = 0;
  int model [DEPTH];
  int head = 0;
  int cnt = 0;

  always #2.5 clk = ~clk;

  exact_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst(rst), .pushValid(pushValid), .pushData(pushData),
    .isFull(isFull), .popReady(popReady), .popData(popData),
    .isEmpty(isEmpty), .fillLevel(fillLevel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkStatus(input string tag);
    chk({tag, " level"}, int'(fillLevel), cnt);
    chk({tag, " full"},  int'(isFull),  int'(cnt == DEPTH));
    chk({tag, " empty"}, int'(isEmpty), int'(cnt == 0));
  endtask

  // One cycle: drive at negedge, check head data, accept at posedge, check status at negedge
  task automatic step(input logic w, input logic [WIDTH-1:0] d, input logic r, input string tag);
    bit wAcc, rAcc;
    pushValid = w; pushData = d; popReady = r;
    #1;
    if (cnt > 0) chk({tag, " head data"}, int'(popData), model[head]);
    wAcc = w && (cnt < DEPTH);
    rAcc = r && (cnt > 0);
    @(posedge clk);
    if (wAcc) model[(head + cnt) % DEPTH] = int'(d);
    if (rAcc) begin head = (head + 1) % DEPTH; cnt--; end
    if (wAcc) cnt++;
    @(negedge clk);
    pushValid = 0; popReady = 0;
    chkStatus(tag);
  endtask

  task automatic testReset();
    chk("R1 empty after reset", int'(isEmpty), 1);
    chk("R1 full after reset", int'(isFull), 0);
    chk("R1 level after reset", int'(fillLevel), 0);
  endtask

  task automatic testFillDrain();
    for (int i = 0; i < DEPTH - 1; i++) step(1, WIDTH'(8'h30 + i), 0, "R3 fill");
    chk("R3 not full at DEPTH-1", int'(isFull), 0);
    step(1, WIDTH'(8'h30 + DEPTH - 1), 0, "R3 last write");
    chk("R3 full at DEPTH", int'(isFull), 1);
    chk("R3 level at DEPTH", int'(fillLevel), DEPTH);
    step(1, 8'hEE, 0, "R4 push while full");
    chk("R4 level kept", int'(fillLevel), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 fall-through order", int'(popData), 8'h30 + i);
      step(0, 8'h00, 1, "R2 drain");
    end
    step(0, 8'h00, 1, "R5 pop while empty");
    chk("R5 level stays 0", int'(fillLevel), 0);
    step(1, 8'h77, 0, "R5 recover write");
    chk("R5 recover data", int'(popData), 8'h77);
    step(0, 8'h00, 1, "R5 recover read");
  endtask

  task automatic testSimul();
    for (int i = 0; i < 3; i++) step(1, WIDTH'(8'h50 + i), 0, "R6 prefill");
    for (int i = 0; i < 10; i++) begin
      step(1, WIDTH'(8'h60 + i), 1, "R6 push+pop");
      chk("R6 level unchanged", int'(fillLevel), 3);
    end
    while (cnt > 0) step(0, 8'h00, 1, "R6 drain");
  endtask

  task automatic testLimits();
    for (int i = 0; i < DEPTH; i++) step(1, WIDTH'(8'h90 + i), 0, "R7 fill");
    step(1, 8'hAA, 1, "R7 both at full");
    chk("R7 level after both at full", int'(fillLevel), DEPTH - 1);
    while (cnt > 0) step(0, 8'h00, 1, "R7 drain");
    step(1, 8'hBB, 1, "R7 both at empty");
    chk("R7 level after both at empty", int'(fillLevel), 1);
    chk("R7 stored write", int'(popData), 8'hBB);
    step(0, 8'h00, 1, "R7 final read");
  endtask

  task automatic testLatency();
    pushValid = 1; pushData = 8'h11; #1;
    chk("R10 level before edge", int'(fillLevel), 0);
    chk("R10 empty before edge", int'(isEmpty), 1);
    @(posedge clk);
    model[(head + cnt) % DEPTH] = 8'h11; cnt++;
    @(negedge clk);
    pushValid = 0;
    chk("R10 level after edge", int'(fillLevel), 1);
    chk("R10 empty after edge", int'(isEmpty), 0);
    step(0, 8'h00, 1, "R10 cleanup");
  endtask

  task automatic testLaps();
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[3], WIDTH'(i), lfsr[1] | lfsr[6], "R9 laps / R8 level");
    end
    while (cnt > 0) step(0, 8'h00, 1, "R9 final drain");
    chk("R8 level after laps", int'(fillLevel), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    testReset();
    testFillDrain();
    testSimul();
    testLimits();
    testLatency();
    testLaps();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule